// File: doc/BRIEF.md
# Triggered Parallel Input Capture Controller

This block decides which samples of a 32-bit parallel input are written into a downstream FIFO. A sample enable is made from the system clock by dividing it by 3, 4 or 6. With a 60 MHz system clock these give 20, 15 and 10 MHz. The sample enable can instead follow the rising edges of an external clock pin. A capture session opens on a start event and closes on a stop event. Each event can come from a software pulse, from a chosen edge on a trigger pin, or from the first sample at which the masked input equals a masked pattern. The event takes effect at the next sample enable that follows it.

A session can be finite: it ends when a programmed number of samples has been written. In change mode, a sample is written only if it differs from the previous sample on the channels that are selected for watching. Each write is a one-cycle strobe with the data. One-cycle interrupt pulses report that the count was reached, that the pattern matched, that a change was captured, and that a sample was dropped because the FIFO was full.

The control is a three-state machine:
- **IDLE** waits for a start event.
- **RUN** captures samples.
- **DONE** holds after a finite session.

The transitions are:
- **IDLE→RUN**: a start is pending at a sample enable.
- **IDLE→DONE**: that first capture already reaches a count of one.
- **RUN→IDLE**: a stop is pending at a sample enable.
- **RUN→DONE**: the finite count is reached.
- **DONE→IDLE**: a software stop pulse.

Top module: `pcap_ctrl`

## Requirements
- R1: The sample enable comes from `cfg_rate`. Code 0 gives one sample every 3 system clocks, code 1 every 4, code 2 every 6. Code 3 gives one sample per rising edge of `ext_clk`, after a two-stage synchronizer. After reset the first internal sample enable falls on the DIV-th rising clock edge.
- R2: A start event is taken at the first sample enable strictly after the cycle of the event. That sample is written. While RUN, every sample is written (normal mode). A write is a one-cycle `fifo_wr` in the cycle after the sample enable, with `fifo_data` equal to `din` at that enable. `busy` is high in RUN.
- R3: A stop event seen in RUN returns the block to IDLE at the first sample enable strictly after the event. That sample is not written.
- R4: Start source code: 0 = `sw_start`, 1 = edge on `start_pin`, 2 = pattern match. Stop source code: 0 = `sw_stop`, 1 = edge on `stop_pin`, 2 = pattern match, 3 = none. A polarity bit of 0 selects the rising edge and 1 the falling edge. Events from sources that are not selected are ignored. Start events are ignored outside IDLE, and stop events outside RUN.
- R5: The pattern matches when `(din & cfg_mask) == (cfg_pattern & cfg_mask)` at a sample enable. It fires only on a sample that matches after a sample that did not match, with the state cleared at reset. Each firing gives a one-cycle `irq_match`.
- R6: `cfg_err` is high when any of these holds: both sources are set to pattern, the start source code is 3, or a finite session has a count of 0. While it is high, no session starts.
- R7: In a finite session, the write that brings the accepted count to `cfg_count` gives a one-cycle `irq_count`, and the block enters DONE (`done` high, `busy` low). It makes no further writes until `sw_stop` returns it to IDLE.
- R8: In change mode (`cfg_chg_mode` = 1), a sample in a session is captured only if it differs from the previous sample in some bit set in `cfg_chg_sel`. Each such capture gives a one-cycle `irq_change`.
- R9: A capture while `fifo_full` is high makes no write, gives a one-cycle `irq_ovf`, and is not counted toward the finite count.
- R10: During and right after reset, every output except `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rate | input | 2 | Sample rate select |
| ext_clk | input | 1 | External sample clock |
| cfg_start_src | input | 2 | Start source code |
| cfg_stop_src | input | 2 | Stop source code |
| cfg_start_fall | input | 1 | Start pin edge polarity |
| cfg_stop_fall | input | 1 | Stop pin edge polarity |
| cfg_chg_mode | input | 1 | Change-detection mode |
| cfg_finite | input | 1 | Finite session enable |
| cfg_count | input | 16 | Finite sample count |
| cfg_mask | input | 32 | Pattern compare mask |
| cfg_pattern | input | 32 | Pattern compare value |
| cfg_chg_sel | input | 32 | Channels watched in change mode |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse; also leaves DONE |
| start_pin | input | 1 | Start trigger pin |
| stop_pin | input | 1 | Stop trigger pin |
| din | input | 32 | Parallel input data |
| fifo_full | input | 1 | Downstream FIFO full |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 32 | FIFO write data |
| busy | output | 1 | Session running |
| done | output | 1 | Finite session complete |
| cfg_err | output | 1 | Configuration rejected |
| irq_count | output | 1 | Count reached pulse |
| irq_match | output | 1 | Pattern match pulse |
| irq_change | output | 1 | Change captured pulse |
| irq_ovf | output | 1 | Overflow pulse |

## Verification
The hardest case to reach from the ports is an event that lands in the same cycle as a sample enable. The rules say that sample must not act on it, and only the following one may. Since the divider phase is hidden, the stimulus fires software pulses, pin toggles and full flags at random on every cycle. Runs of many cycles at each rate then make these coincidences common. A cycle-accurate reference model in the bench judges every output on every cycle. Stop events that arrive in the cycle a session opens, and overflow in the middle of a finite count, arise in the same way.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } cap_state_t;

    localparam logic [1:0] SRC_SW   = 2'd0;
    localparam logic [1:0] SRC_EDGE = 2'd1;
    localparam logic [1:0] SRC_PAT  = 2'd2;
    localparam logic [1:0] SRC_NONE = 2'd3;

    localparam logic [1:0] RATE_EXT = 2'd3;
endpackage

// File: rtl/pcap_rate_gen.sv
module pcap_rate_gen #(
    parameter int DIV_A = 3,
    parameter int DIV_B = 4,
    parameter int DIV_C = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    input  logic       ext_clk,
    output logic       tick
);
    import pcap_pkg::*;

    localparam int DIV_MAX = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                             : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
    localparam int CNT_W = $clog2(DIV_MAX + 1);
    localparam int SYNC_N = 3;

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  lim;
    logic [SYNC_N-1:0] ext_q;
    logic              int_tick;
    logic              ext_tick;

    always_comb begin
        unique case (rate_sel)
            2'd0:    lim = CNT_W'(DIV_A - 1);
            2'd1:    lim = CNT_W'(DIV_B - 1);
            default: lim = CNT_W'(DIV_C - 1);
        endcase
    end

    assign int_tick = (cnt >= lim);
    assign ext_tick = ext_q[1] & ~ext_q[2];
    assign tick     = (rate_sel == RATE_EXT) ? ext_tick : int_tick;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (rate_sel == RATE_EXT || int_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= '0;
        else        ext_q <= {ext_q[SYNC_N-2:0], ext_clk};
    end

    // R1: internal dividers are at least three, so enables never abut
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != RATE_EXT && tick) |=> !tick);
endmodule

// File: rtl/pcap_edge.sv
module pcap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall,
    output logic evt
);
    logic prev;

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= pin;
    end

    assign evt = fall ? (prev & ~pin) : (~prev & pin);
endmodule

// File: rtl/pcap_watch.sv
module pcap_watch #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] pattern,
    input  logic [DW-1:0] chg_sel,
    output logic          pat_hit,
    output logic          chg_hit
);
    logic          match_now;
    logic          match_prev;
    logic [DW-1:0] last_smp;

    assign match_now = (((din ^ pattern) & mask) == '0);
    assign pat_hit   = tick && match_now && !match_prev;
    assign chg_hit   = tick && (((din ^ last_smp) & chg_sel) != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_prev <= 1'b0;
            last_smp   <= '0;
        end else if (tick) begin
            match_prev <= match_now;
            last_smp   <= din;
        end
    end

    // R5: a match pulse never repeats on back-to-back cycles
    a_r5_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pat_hit |=> !pat_hit);
endmodule

// File: rtl/pcap_ctrl.sv
module pcap_ctrl #(
    parameter int DW    = 32,
    parameter int CW    = 16,
    parameter int DIV_A = 3,
    parameter int DIV_B = 4,
    parameter int DIV_C = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_rate,
    input  logic          ext_clk,
    input  logic [1:0]    cfg_start_src,
    input  logic [1:0]    cfg_stop_src,
    input  logic          cfg_start_fall,
    input  logic          cfg_stop_fall,
    input  logic          cfg_chg_mode,
    input  logic          cfg_finite,
    input  logic [CW-1:0] cfg_count,
    input  logic [DW-1:0] cfg_mask,
    input  logic [DW-1:0] cfg_pattern,
    input  logic [DW-1:0] cfg_chg_sel,
    input  logic          sw_start,
    input  logic          sw_stop,
    input  logic          start_pin,
    input  logic          stop_pin,
    input  logic [DW-1:0] din,
    input  logic          fifo_full,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_data,
    output logic          busy,
    output logic          done,
    output logic          cfg_err,
    output logic          irq_count,
    output logic          irq_match,
    output logic          irq_change,
    output logic          irq_ovf
);
    import pcap_pkg::*;

    cap_state_t    state, state_d;
    logic          tick, start_edge, stop_edge, pat_hit, chg_hit;
    logic          start_evt, stop_evt;
    logic          start_pend, start_pend_d, stop_pend, stop_pend_d;
    logic [CW-1:0] cnt, cnt_d;
    logic          cap_go, cap, accept, drop, last;

    pcap_rate_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_rate (
        .clk(clk), .rst_n(rst_n), .rate_sel(cfg_rate), .ext_clk(ext_clk), .tick(tick)
    );

    pcap_edge u_start_edge (
        .clk(clk), .rst_n(rst_n), .pin(start_pin), .fall(cfg_start_fall), .evt(start_edge)
    );

    pcap_edge u_stop_edge (
        .clk(clk), .rst_n(rst_n), .pin(stop_pin), .fall(cfg_stop_fall), .evt(stop_edge)
    );

    pcap_watch #(.DW(DW)) u_watch (
        .clk(clk), .rst_n(rst_n), .tick(tick), .din(din), .mask(cfg_mask),
        .pattern(cfg_pattern), .chg_sel(cfg_chg_sel), .pat_hit(pat_hit), .chg_hit(chg_hit)
    );

    always_comb begin
        unique case (cfg_start_src)
            SRC_SW:   start_evt = sw_start;
            SRC_EDGE: start_evt = start_edge;
            SRC_PAT:  start_evt = pat_hit;
            default:  start_evt = 1'b0;
        endcase
        unique case (cfg_stop_src)
            SRC_SW:   stop_evt = sw_stop;
            SRC_EDGE: stop_evt = stop_edge;
            SRC_PAT:  stop_evt = pat_hit;
            default:  stop_evt = 1'b0;
        endcase
    end

    assign cfg_err = (cfg_start_src == SRC_PAT && cfg_stop_src == SRC_PAT)
                   || (cfg_start_src == SRC_NONE)
                   || (cfg_finite && cfg_count == '0);

    assign cap_go = tick && (((state == ST_IDLE) && start_pend && !cfg_err)
                          || ((state == ST_RUN) && !stop_pend));
    assign cap    = cap_go && (!cfg_chg_mode || chg_hit);
    assign accept = cap && !fifo_full;
    assign drop   = cap && fifo_full;
    assign last   = cfg_finite && accept && (({1'b0, cnt} + 1'b1) == {1'b0, cfg_count});

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (cap_go) state_d = last ? ST_DONE : ST_RUN;
            ST_RUN: begin
                if (tick && stop_pend) state_d = ST_IDLE;
                else if (last)         state_d = ST_DONE;
            end
            ST_DONE: if (sw_stop) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        start_pend_d = (state_d == ST_IDLE) && !cfg_err && (start_evt || (start_pend && !tick));
        stop_pend_d  = (state_d == ST_RUN) && (stop_evt || (stop_pend && !tick));
        cnt_d        = (state_d == ST_RUN) ? cnt + CW'(accept) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            start_pend <= 1'b0;
            stop_pend  <= 1'b0;
            cnt        <= '0;
        end else begin
            state      <= state_d;
            start_pend <= start_pend_d;
            stop_pend  <= stop_pend_d;
            cnt        <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr    <= 1'b0;
            fifo_data  <= '0;
            irq_count  <= 1'b0;
            irq_match  <= 1'b0;
            irq_change <= 1'b0;
            irq_ovf    <= 1'b0;
        end else begin
            fifo_wr    <= accept;
            if (accept) fifo_data <= din;
            irq_count  <= last;
            irq_match  <= pat_hit;
            irq_change <= cap && cfg_chg_mode;
            irq_ovf    <= drop;
        end
    end

    assign busy = (state == ST_RUN);
    assign done = (state == ST_DONE);

    // R2: writes only come out of a session
    a_r2_write_in_session: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (busy || done));
    // R3: a taken stop leaves no write behind it
    a_r3_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop_pend && tick) |=> (!fifo_wr && !busy));
    // R6: a rejected configuration never opens a session
    a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cfg_err) |=> (state != ST_RUN));
    // R7: count pulse coincides with the completed state
    a_r7_count_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq_count |-> done);
    // R9: no write of a sample taken while full
    a_r9_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !$past(fifo_full));
    a_r9_drop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |-> !fifo_wr);
endmodule

// File: tb/pcap_ctrl_tb_top.sv
module pcap_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_rate = 2'd0;
    logic        ext_clk = 1'b0;
    logic [1:0]  cfg_start_src = 2'd0, cfg_stop_src = 2'd0;
    logic        cfg_start_fall = 1'b0, cfg_stop_fall = 1'b0;
    logic        cfg_chg_mode = 1'b0, cfg_finite = 1'b0;
    logic [15:0] cfg_count = 16'd1;
    logic [31:0] cfg_mask = '0, cfg_pattern = '0, cfg_chg_sel = '0;
    logic        sw_start = 1'b0, sw_stop = 1'b0, start_pin = 1'b0, stop_pin = 1'b0;
    logic [31:0] din = '0;
    logic        fifo_full = 1'b0;
    logic        fifo_wr, busy, done, cfg_err, irq_count, irq_match, irq_change, irq_ovf;
    logic [31:0] fifo_data;

    int checks = 0, fails = 0, cyc = 0, wr_seen = 0, wr_first = -1, wr_second = -1;
    bit chk_en = 1'b1, rnd_on = 1'b0;

    // reference model state
    int m_st, m_ph, m_cnt;
    bit m_spend, m_ppend, m_pm, m_pst, m_pstp;
    logic [31:0] m_pd;
    bit e_wr, e_cnt, e_match, e_chg, e_ovf;
    logic [31:0] e_data;

    always #2 clk = ~clk;

    pcap_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .ext_clk(ext_clk),
        .cfg_start_src(cfg_start_src), .cfg_stop_src(cfg_stop_src),
        .cfg_start_fall(cfg_start_fall), .cfg_stop_fall(cfg_stop_fall),
        .cfg_chg_mode(cfg_chg_mode), .cfg_finite(cfg_finite), .cfg_count(cfg_count),
        .cfg_mask(cfg_mask), .cfg_pattern(cfg_pattern), .cfg_chg_sel(cfg_chg_sel),
        .sw_start(sw_start), .sw_stop(sw_stop), .start_pin(start_pin), .stop_pin(stop_pin),
        .din(din), .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .busy(busy), .done(done), .cfg_err(cfg_err), .irq_count(irq_count),
        .irq_match(irq_match), .irq_change(irq_change), .irq_ovf(irq_ovf)
    );

    function automatic bit bad_cfg();
        return (cfg_start_src == 2 && cfg_stop_src == 2) || cfg_start_src == 3
            || (cfg_finite && cfg_count == 0);
    endfunction

    function automatic int div_of(input logic [1:0] r);
        return (r == 0) ? 3 : (r == 1) ? 4 : 6;
    endfunction

    always @(posedge clk) begin
        bit tk, se, pe, mt, ph, ch, sev, pev, er, go, cp, ac, dr, lst;
        int nst;
        if (!rst_n) begin
            m_st = 0; m_ph = 0; m_cnt = 0; m_spend = 0; m_ppend = 0; m_pm = 0;
            m_pd = '0; m_pst = 0; m_pstp = 0;
            e_wr = 0; e_cnt = 0; e_match = 0; e_chg = 0; e_ovf = 0; e_data = '0;
        end else begin
            tk = (cfg_rate != 3) && (m_ph >= div_of(cfg_rate) - 1);
            m_ph = (cfg_rate == 3 || tk) ? 0 : m_ph + 1;
            se = cfg_start_fall ? (m_pst && !start_pin) : (!m_pst && start_pin);
            pe = cfg_stop_fall ? (m_pstp && !stop_pin) : (!m_pstp && stop_pin);
            m_pst = start_pin; m_pstp = stop_pin;
            mt = (((din ^ cfg_pattern) & cfg_mask) == 0);
            ph = tk && mt && !m_pm;
            ch = tk && (((din ^ m_pd) & cfg_chg_sel) != 0);
            if (tk) begin m_pm = mt; m_pd = din; end
            sev = (cfg_start_src == 0) ? sw_start : (cfg_start_src == 1) ? se :
                  (cfg_start_src == 2) ? ph : 1'b0;
            pev = (cfg_stop_src == 0) ? sw_stop : (cfg_stop_src == 1) ? pe :
                  (cfg_stop_src == 2) ? ph : 1'b0;
            er = bad_cfg();
            go = tk && ((m_st == 0 && m_spend && !er) || (m_st == 1 && !m_ppend));
            cp = go && (!cfg_chg_mode || ch);
            ac = cp && !fifo_full;
            dr = cp && fifo_full;
            lst = cfg_finite && ac && (m_cnt + 1 == int'(cfg_count));
            nst = m_st;
            if (m_st == 0 && go) nst = lst ? 2 : 1;
            else if (m_st == 1 && tk && m_ppend) nst = 0;
            else if (m_st == 1 && lst) nst = 2;
            else if (m_st == 2 && sw_stop) nst = 0;
            m_spend = (nst == 0) && !er && (sev || (m_spend && !tk));
            m_ppend = (nst == 1) && (pev || (m_ppend && !tk));
            m_cnt = (nst == 1) ? m_cnt + int'(ac) : 0;
            m_st = nst;
            e_wr = ac; if (ac) e_data = din;
            e_cnt = lst; e_match = ph; e_chg = cp && cfg_chg_mode; e_ovf = dr;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (fifo_wr) begin
            wr_seen++;
            if (wr_first < 0) wr_first = cyc;
            else if (wr_second < 0) wr_second = cyc;
        end
        if (chk_en && rst_n) begin
            chk(fifo_wr == e_wr, "R2 write strobe", 32'(fifo_wr), 32'(e_wr));
            if (e_wr) chk(fifo_data == e_data, "R2 write data", fifo_data, e_data);
            chk(busy == (m_st == 1), "R3 busy", 32'(busy), 32'(m_st == 1));
            chk(done == (m_st == 2), "R7 done", 32'(done), 32'(m_st == 2));
            chk(irq_count == e_cnt, "R7 irq_count", 32'(irq_count), 32'(e_cnt));
            chk(irq_match == e_match, "R5 irq_match", 32'(irq_match), 32'(e_match));
            chk(irq_change == e_chg, "R8 irq_change", 32'(irq_change), 32'(e_chg));
            chk(irq_ovf == e_ovf, "R9 irq_ovf", 32'(irq_ovf), 32'(e_ovf));
            chk(cfg_err == bad_cfg(), "R6 cfg_err", 32'(cfg_err), 32'(bad_cfg()));
        end
        if (rnd_on) begin
            sw_start  = ($urandom % 16) == 0;
            sw_stop   = ($urandom % 24) == 0;
            if (($urandom % 10) == 0) start_pin = ~start_pin;
            if (($urandom % 12) == 0) stop_pin = ~stop_pin;
            fifo_full = ($urandom % 8) == 0;
            if (($urandom % 3) == 0) din = {$urandom, 4'h0} | 32'($urandom % 16);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        run(3);
        // R10: outputs quiet while held in reset
        chk({fifo_wr, busy, done, irq_count, irq_match, irq_change, irq_ovf} == 7'b0,
            "R10 reset outputs", 32'({fifo_wr, busy, done, irq_count, irq_match, irq_change, irq_ovf}), 32'd0);
        rst_n = 1'b1;
        wr_seen = 0; wr_first = -1; wr_second = -1;
    endtask

    task automatic pulse_start();
        sw_start = 1'b1; step(); sw_start = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2718));
        do_reset();
        step();
        chk(fifo_data == 0 && !busy && !done, "R10 after reset", {fifo_data[30:0], busy}, 32'd0);

        // R4: edge source ignores software start, then a rising pin starts
        cfg_start_src = 2'd1; cfg_stop_src = 2'd0;
        do_reset();
        pulse_start(); run(20);
        chk(busy == 1'b0, "R4 software start ignored", 32'(busy), 32'd0);
        start_pin = 1'b1; run(10);
        chk(busy == 1'b1, "R2 pin start", 32'(busy), 32'd1);
        sw_stop = 1'b1; step(); sw_stop = 1'b0; run(10);
        chk(busy == 1'b0, "R3 software stop", 32'(busy), 32'd0);
        start_pin = 1'b0;

        // R1: divide-by-6 spacing of writes
        cfg_rate = 2'd2; cfg_start_src = 2'd0; cfg_stop_src = 2'd3;
        do_reset();
        pulse_start(); run(20);
        chk(wr_second - wr_first == 6, "R1 divide-by-6 spacing", 32'(wr_second - wr_first), 32'd6);

        // R6: pattern chosen for both start and stop is rejected
        cfg_rate = 2'd0; cfg_start_src = 2'd2; cfg_stop_src = 2'd2;
        cfg_mask = 32'hFF; cfg_pattern = 32'h5A; din = 32'h0;
        do_reset();
        run(6); din = 32'h5A; run(12);
        chk(cfg_err == 1'b1 && busy == 1'b0, "R6 rejected config", {cfg_err, busy}, 32'h2);

        // R7: finite count of three
        cfg_start_src = 2'd0; cfg_stop_src = 2'd3; cfg_finite = 1'b1; cfg_count = 16'd3;
        do_reset();
        pulse_start(); run(30);
        chk(done == 1'b1 && wr_seen == 3, "R7 finite three", 32'(wr_seen), 32'd3);
        sw_stop = 1'b1; step(); sw_stop = 1'b0; step();
        chk(done == 1'b0, "R7 leave done", 32'(done), 32'd0);
        cfg_finite = 1'b0;

        // R1: external clock, one write per rising edge
        chk_en = 1'b0; cfg_rate = 2'd3;
        do_reset();
        pulse_start(); run(5);
        for (int k = 0; k < 10; k++) begin
            ext_clk = 1'b1; run(4); ext_clk = 1'b0; run(4);
        end
        run(6);
        chk(wr_seen == 10, "R1 external edges", 32'(wr_seen), 32'd10);
        chk_en = 1'b1; cfg_rate = 2'd0;

        // random sessions against the model (R2 R3 R4 R5 R7 R8 R9)
        for (int s = 0; s < 48; s++) begin
            rnd_on = 1'b0;
            cfg_rate = 2'($urandom % 3);
            cfg_start_src = 2'($urandom % 3);
            cfg_stop_src = 2'($urandom % 4);
            if ((s % 7) == 3) begin cfg_start_src = 2'd2; cfg_stop_src = 2'd2; end
            cfg_start_fall = 1'($urandom); cfg_stop_fall = 1'($urandom);
            cfg_chg_mode = 1'($urandom);
            cfg_finite = 1'($urandom);
            cfg_count = 16'($urandom % 9);
            cfg_mask = 32'h0000_000F | (32'($urandom) & 32'h0100_0000);
            cfg_pattern = 32'($urandom % 16);
            cfg_chg_sel = 32'h0000_0003 << ($urandom % 3);
            do_reset();
            rnd_on = 1'b1;
            run(260);
        end
        rnd_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule